// File: doc/BRIEF.md
# Low-Power Mode Entry Arbiter

This block decides which power mode a small controller really enters when its CPU asks for a low-power mode. Every peripheral reports how much clock it currently needs: none, a slow clock of 50 kHz or less, or a fast clock above 50 kHz. A peripheral that is waiting for an event without using a clock, such as a serial receiver waiting for a start edge or a bus target waiting for a start condition, reports "none". The arbiter derives a ceiling from these reports and grants the deeper of nothing beyond it: the smaller of the requested mode and the ceiling. When a peripheral runs from an external clock, the ceiling is bypassed and the request is granted as asked. Accelerators that only work in active mode (checksum, multiplier, cipher) hold the grant at active mode while any of them is busy.

A DMA trigger wakes the controller to active mode for the length of the transfer. When the transfer ends, the arbiter recomputes the grant from the request and demands of that cycle. The grant therefore returns to the previous mode if nothing else changed. The granted mode drives two clock enables and a one-cycle wake indication.

The control is a two-state machine. `ST_SETTLED` is the normal state: the grant follows the clamped target on every clock. `ST_DMA_XFER` holds the grant at active mode. Its transitions are named as follows:
- **dma_start** (`ST_SETTLED` to `ST_DMA_XFER`): taken on a DMA trigger.
- **dma_finish** (`ST_DMA_XFER` to `ST_SETTLED`): taken on a done pulse with no new trigger in the same cycle.
- **dma_extend** (`ST_DMA_XFER` to itself): taken when a new trigger arrives, or when no done pulse has arrived yet.

Top module: `lpm_arbiter`

## Requirements
- R1: The mode code is 2 bits: 0 = active, 1 = light sleep (fast and slow clocks available), 2 = deep sleep (slow clock only), 3 = off (no clocks). The granted mode is never deeper than the request sampled at the previous clock edge.
- R2: Each peripheral's demand field is 2 bits wide. Peripheral k sits at bits [2k+1:2k]. Code 00 means no clock, 01 means a slow clock, and 10 or 11 means a fast clock. Without an external clock, the ceiling is 1 if any field asks for a fast clock, else 2 if any field asks for a slow clock, else 3. At each edge the grant becomes the smaller of the request and the ceiling, so a rise in demand lowers the grant within one clock.
- R3: While the external-clock input is high, the ceiling from the demand fields is ignored and the request is granted as asked (rules R4 and R5 still apply).
- R4: While any accelerator busy bit is high, the grant taken at the next edge is 0. Once all busy bits are low, the grant returns to the clamped request at the next edge.
- R5: A DMA trigger forces the grant to 0 from the next edge. The grant stays at 0 until an edge where done is high and no new trigger is present. At that edge the grant becomes the clamped target again.
- R6: The reset input is active-low and asynchronous. Reset gives a grant of 0, both clock enables high, the wake output low and no DMA transfer pending.
- R7: The fast-clock enable is high only in modes 0 and 1. The slow-clock enable is high in modes 0, 1 and 2.
- R8: The wake output is high for exactly one cycle, the first cycle of a DMA hold, and only when the grant just before the hold was nonzero.
- R9: A request of mode 0 yields grant 0 at the next edge, whatever the demands, the external-clock input or the DMA state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_mode_i | input | 2 | Mode requested by the CPU |
| periph_demand_i | input | 2*N_PERIPH | Packed per-peripheral clock demand fields |
| accel_busy_i | input | N_ACCEL | Busy flags of the active-only accelerators |
| dma_trig_i | input | 1 | DMA transfer trigger |
| dma_done_i | input | 1 | DMA transfer complete |
| ext_clk_i | input | 1 | A peripheral runs from an external clock; bypass the ceiling |
| grant_mode_o | output | 2 | Mode actually entered |
| hf_clk_en_o | output | 1 | Fast clock enable |
| lf_clk_en_o | output | 1 | Slow clock enable |
| wake_o | output | 1 | One-cycle pulse on a DMA wakeup from a low-power mode |

## Verification
Some properties are checked on every cycle: the grant never exceeds the prior request, busy flags and DMA triggers force active mode, a fast-clock demand caps the grant at 1, the external-clock override returns the request, and the enables and the wake pulse stay consistent with the grant. Other behaviour is shown only by the bench's scenarios. These cover the exact grant value after a demand change, the return to the earlier mode after a DMA transfer ends, the lengthening of a hold by a new trigger, and the reserved demand code 11. A behavioural reference model compares all outputs on every clock, over directed sequences and a long stretch of random stimulus.

// File: rtl/lpm_arb_pkg.sv
package lpm_arb_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_LIGHT  = 2'd1,
        MODE_DEEP   = 2'd2,
        MODE_OFF    = 2'd3
    } pwr_mode_e;

    typedef enum logic {
        ST_SETTLED  = 1'b0,
        ST_DMA_XFER = 1'b1
    } arb_state_e;

    localparam int DEMAND_W = 2;
    localparam logic [DEMAND_W-1:0] DEM_NONE = 2'b00;
    localparam logic [DEMAND_W-1:0] DEM_SLOW = 2'b01;

endpackage

// File: rtl/lpm_demand_ceiling.sv
module lpm_demand_ceiling
    import lpm_arb_pkg::*;
#(
    parameter int N_PERIPH = 6,
    parameter int N_ACCEL  = 3
) (
    input  logic [DEMAND_W*N_PERIPH-1:0] demand_i,
    input  logic [N_ACCEL-1:0]           busy_i,
    output pwr_mode_e                    ceiling_o,
    output logic                         any_busy_o
);

    logic [N_PERIPH-1:0] fast_w;
    logic [N_PERIPH-1:0] slow_w;

    for (genvar g = 0; g < N_PERIPH; g++) begin : g_field
        // top bit of a field marks fast demand (codes 10 and 11)
        assign fast_w[g] = demand_i[DEMAND_W*g+1];
        assign slow_w[g] = (demand_i[DEMAND_W*g +: DEMAND_W] == DEM_SLOW);
    end

    assign any_busy_o = |busy_i;

    always_comb begin
        if (any_busy_o)       ceiling_o = MODE_ACTIVE;
        else if (|fast_w)     ceiling_o = MODE_LIGHT;
        else if (|slow_w)     ceiling_o = MODE_DEEP;
        else                  ceiling_o = MODE_OFF;
    end

endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
    import lpm_arb_pkg::*;
(
    input  pwr_mode_e mode_i,
    output logic      hf_en_o,
    output logic      lf_en_o
);

    always_comb begin
        hf_en_o = 1'b0;
        lf_en_o = 1'b0;
        unique case (mode_i)
            MODE_ACTIVE: begin hf_en_o = 1'b1; lf_en_o = 1'b1; end
            MODE_LIGHT:  begin hf_en_o = 1'b1; lf_en_o = 1'b1; end
            MODE_DEEP:   begin hf_en_o = 1'b0; lf_en_o = 1'b1; end
            MODE_OFF:    begin hf_en_o = 1'b0; lf_en_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/lpm_arbiter.sv
module lpm_arbiter
    import lpm_arb_pkg::*;
#(
    parameter int N_PERIPH = 6,
    parameter int N_ACCEL  = 3
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [1:0]                   req_mode_i,
    input  logic [DEMAND_W*N_PERIPH-1:0] periph_demand_i,
    input  logic [N_ACCEL-1:0]           accel_busy_i,
    input  logic                         dma_trig_i,
    input  logic                         dma_done_i,
    input  logic                         ext_clk_i,
    output logic [1:0]                   grant_mode_o,
    output logic                         hf_clk_en_o,
    output logic                         lf_clk_en_o,
    output logic                         wake_o
);

    arb_state_e state_q, state_d;
    pwr_mode_e  grant_q, grant_d;
    logic       wake_q,  wake_d;
    pwr_mode_e  ceiling_w, req_w, target_w;
    logic       any_busy_w;

    lpm_demand_ceiling #(
        .N_PERIPH (N_PERIPH),
        .N_ACCEL  (N_ACCEL)
    ) u_ceiling (
        .demand_i   (periph_demand_i),
        .busy_i     (accel_busy_i),
        .ceiling_o  (ceiling_w),
        .any_busy_o (any_busy_w)
    );

    assign req_w = pwr_mode_e'(req_mode_i);

    // clamped target: the override keeps only the busy rule
    always_comb begin
        if (ext_clk_i)
            target_w = any_busy_w ? MODE_ACTIVE : req_w;
        else
            target_w = (req_w < ceiling_w) ? req_w : ceiling_w;
    end

    // next state and next outputs
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        wake_d  = 1'b0;
        unique case (state_q)
            ST_SETTLED: begin
                if (dma_trig_i) begin            // dma_start
                    state_d = ST_DMA_XFER;
                    grant_d = MODE_ACTIVE;
                    wake_d  = (grant_q != MODE_ACTIVE);
                end else begin
                    grant_d = target_w;
                end
            end
            ST_DMA_XFER: begin
                if (dma_done_i && !dma_trig_i) begin   // dma_finish
                    state_d = ST_SETTLED;
                    grant_d = target_w;
                end else begin                          // dma_extend
                    grant_d = MODE_ACTIVE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_SETTLED;
        else         state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            grant_q <= MODE_ACTIVE;
            wake_q  <= 1'b0;
        end else begin
            grant_q <= grant_d;
            wake_q  <= wake_d;
        end
    end

    lpm_clk_decode u_clk (
        .mode_i  (grant_q),
        .hf_en_o (hf_clk_en_o),
        .lf_en_o (lf_clk_en_o)
    );

    assign grant_mode_o = grant_q;
    assign wake_o       = wake_q;

    // ---------------- assertions ----------------
    p_not_deeper_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (grant_mode_o <= $past(req_mode_i)));

    p_fast_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ext_clk_i && ceiling_w == MODE_LIGHT) |=> (grant_mode_o <= 2'd1));

    p_override_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_clk_i && !any_busy_w && state_q == ST_SETTLED && !dma_trig_i)
        |=> (grant_mode_o == $past(req_mode_i)));

    p_busy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|accel_busy_i) |=> (grant_mode_o == 2'd0));

    p_dma_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_trig_i |=> (grant_mode_o == 2'd0));

    p_enables_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hf_clk_en_o |-> lf_clk_en_o);

    p_wake_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> (grant_mode_o == 2'd0 && $past(grant_mode_o) != 2'd0));

    p_wake_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    p_active_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_mode_i == 2'd0) |=> (grant_mode_o == 2'd0));

endmodule

// File: tb/lpm_arbiter_bench.sv
module lpm_arbiter_bench;

    localparam int NP = 6;
    localparam int NA = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      req = 2'd0;
    logic [2*NP-1:0] dem = '0;
    logic [NA-1:0]   busy = '0;
    logic            trig = 1'b0;
    logic            done = 1'b0;
    logic            ext = 1'b0;
    logic [1:0]      grant;
    logic            hf_en, lf_en, wake;

    always #2 clk = ~clk;   // 250 MHz

    lpm_arbiter #(.N_PERIPH(NP), .N_ACCEL(NA)) u_lpm_arbiter (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .req_mode_i      (req),
        .periph_demand_i (dem),
        .accel_busy_i    (busy),
        .dma_trig_i      (trig),
        .dma_done_i      (done),
        .ext_clk_i       (ext),
        .grant_mode_o    (grant),
        .hf_clk_en_o     (hf_en),
        .lf_clk_en_o     (lf_en),
        .wake_o          (wake)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R6";
    bit    finished = 1'b0;

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_grant = 0;
    int m_wake  = 0;
    int m_hold  = 0;

    function automatic int ref_target();
        int need = 3;
        int t;
        for (int k = 0; k < NP; k++) begin
            int code = int'(dem[2*k +: 2]);
            if (code >= 2 && need > 1) need = 1;
            else if (code == 1 && need > 2) need = 2;
        end
        if (busy != 0) need = 0;
        if (ext) t = (busy != 0) ? 0 : int'(req);
        else     t = (int'(req) < need) ? int'(req) : need;
        return t;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_grant = 0; m_wake = 0; m_hold = 0;
        end else if (m_hold == 0) begin
            if (trig) begin
                m_wake = (m_grant != 0) ? 1 : 0;
                m_grant = 0; m_hold = 1;
            end else begin
                m_wake = 0; m_grant = ref_target();
            end
        end else begin
            m_wake = 0;
            if (done && !trig) begin m_hold = 0; m_grant = ref_target(); end
            else m_grant = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cur_req, "grant", int'(grant), m_grant);
            chk("R7", "hf_en", int'(hf_en), (m_grant <= 1) ? 1 : 0);
            chk("R7", "lf_en", int'(lf_en), (m_grant <= 2) ? 1 : 0);
            chk("R8", "wake",  int'(wake), m_wake);
        end
    end

    // ---------------- watchdog ----------------
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tick(3);
        // reset state (R6)
        chk("R6", "grant in reset", int'(grant), 0);
        chk("R6", "hf in reset", int'(hf_en), 1);
        chk("R6", "lf in reset", int'(lf_en), 1);
        chk("R6", "wake in reset", int'(wake), 0);
        rst_n = 1'b1;
        tick(2);

        // full depth with no demand, then active request (R9, R1)
        cur_req = "R1";
        req = 2'd3; tick(1);
        chk("R1", "deepest grant", int'(grant), 3);
        chk("R7", "lf off in mode 3", int'(lf_en), 0);
        cur_req = "R9";
        dem = 12'b10_00_00_00_00_00; req = 2'd0; tick(1);
        chk("R9", "active request", int'(grant), 0);
        req = 2'd2; dem = '0; tick(1);
        chk("R1", "grant equals shallower request", int'(grant), 2);

        // demand clamp (R2)
        cur_req = "R2";
        req = 2'd3; dem = 12'b00_00_01_00_00_00; tick(1);
        chk("R2", "slow demand ceiling", int'(grant), 2);
        dem = 12'b00_00_01_00_10_00; tick(1);
        chk("R2", "fast demand ceiling", int'(grant), 1);
        dem = 12'b11_00_00_00_00_00; tick(1);
        chk("R2", "reserved code is fast", int'(grant), 1);
        dem = '0; tick(1);
        chk("R2", "demand cleared", int'(grant), 3);

        // external clock override (R3)
        cur_req = "R3";
        ext = 1'b1; dem = 12'b00_10_00_00_00_01; tick(1);
        chk("R3", "override grants request", int'(grant), 3);
        busy = 3'b010; tick(1);
        chk("R4", "busy under override", int'(grant), 0);
        busy = '0; ext = 1'b0; tick(1);
        chk("R3", "override removed", int'(grant), 1);
        dem = '0;

        // busy accelerators (R4)
        cur_req = "R4";
        busy = 3'b100; tick(1);
        chk("R4", "busy defers entry", int'(grant), 0);
        tick(2);
        busy = '0; tick(1);
        chk("R4", "resume after busy", int'(grant), 3);

        // DMA wakeup (R5, R8)
        cur_req = "R5";
        trig = 1'b1; tick(1);
        trig = 1'b0;
        chk("R5", "dma forces active", int'(grant), 0);
        chk("R8", "wake pulse", int'(wake), 1);
        tick(1);
        chk("R8", "wake single cycle", int'(wake), 0);
        tick(2);
        chk("R5", "still held", int'(grant), 0);
        done = 1'b1; trig = 1'b1; tick(1);
        chk("R5", "done with new trigger extends", int'(grant), 0);
        trig = 1'b0; tick(1);
        done = 1'b0;
        chk("R5", "resume prior mode", int'(grant), 3);
        req = 2'd0; tick(1);
        trig = 1'b1; tick(1);
        trig = 1'b0; done = 1'b1;
        chk("R8", "no wake from active", int'(wake), 0);
        tick(1); done = 1'b0;

        // random stretch, model compares every clock
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            req  = 2'($urandom_range(0, 3));
            dem  = 12'($urandom);
            for (int k = 0; k < NP; k++)
                if ($urandom_range(0, 2) != 0) dem[2*k +: 2] = 2'b00;
            busy = ($urandom_range(0, 7) == 0) ? 3'($urandom) : '0;
            ext  = ($urandom_range(0, 9) == 0);
            trig = ($urandom_range(0, 19) == 0);
            done = ($urandom_range(0, 3) == 0);
            tick(1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule